// File: doc/BRIEF.md
# Eight-Channel External Interrupt Controller

This block watches eight external interrupt pins and turns activity on them into interrupt requests for a small processor core. Each pin has a 2-bit sense mode: low level, any change, falling edge or rising edge. Every pin input first passes through a two-flop synchronizer. Edges are found by comparing the synchronized value with its value one clock earlier.

An edge that matches a channel's sense mode sets that channel's pending flag, whatever the channel's mask bit holds. A channel raises a request only when two things are both set: the core's global interrupt enable and the channel's mask bit. When several channels request at once, the lowest index is presented. The core clears a flag in one of two ways: it acknowledges the serviced index, or it writes ones to the flag register. If a channel drives its own pin as an output, the driven value is what gets sensed. This lets software force an interrupt by writing the pin.

Changing a channel's sense mode while the channel is enabled can create a spurious flag. The block does not mask this, so software should clear the mask bit first.

Top module: `ext_irq_ctrl`

## Requirements
- R1: After reset, the sense, mask and flag registers read 0, and `irq_valid` is 0.
- R2: The register address selects a register as follows. Address 0 holds the sense modes for pins 3..0, and address 1 holds them for pins 7..4; pin i uses bits [2(i mod 4)+1 : 2(i mod 4)]. Address 2 is the mask, with bit i for pin i. Address 3 is the flag register. Mask and sense registers read back the value written.
- R3: A non-level channel sets its flag on the edge its mode selects (01 any change, 10 falling, 11 rising), whether or not its mask bit is set. The flag becomes visible three clock edges after the pin changes.
- R4: Writing to address 3 clears each flag whose data bit is 1. Bits written as 0 leave their flags unchanged.
- R5: An acknowledge clears the flag of the channel given by `ack_index` on the next clock edge.
- R6: In mode 00 a channel's flag always reads 0. The channel requests while its synchronized pin is low, two clock edges after the pin falls, and stops once the pin is high again.
- R7: `irq_valid` is 1 only when `gie` is 1 and at least one channel with its mask bit set is pending.
- R8: When several channels are pending and enabled, `irq_index` gives the lowest index among them.
- R9: When `pad_oe[i]` is 1, the channel senses `pad_out[i]` in place of `pad_in[i]`, so a driven pin can trigger its own interrupt.
- R10: When a new qualifying edge and a clear by write or acknowledge arrive in the same cycle, the flag ends up set.
- R11: An edge that the channel's mode does not select leaves its flag at 0. Examples are a falling edge in mode 11 and a rising edge in mode 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 2 | Register select: 0/1 sense, 2 mask, 3 flags |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| pad_in | input | 8 | Pin values from the pads |
| pad_oe | input | 8 | Per-pin output enable |
| pad_out | input | 8 | Per-pin driven output value |
| gie | input | 1 | Global interrupt enable from the core |
| ack_valid | input | 1 | Acknowledge strobe |
| ack_index | input | 3 | Index of the serviced channel |
| irq_valid | output | 1 | An enabled request is pending |
| irq_index | output | 3 | Lowest pending enabled channel |

## Verification
The bench walks every sense mode through both edge directions. A design with mis-decoded modes would set flags on the wrong edge, or would leave a flag standing on a level channel.

It checks request gating with the mask bit and `gie` each off in turn. A design that ORed the two enables, or gated the flag instead of the request, would raise `irq_valid` too early or lose the flag.

It checks that the lowest pending index is presented and that an acknowledge moves the output on to the next one. A reversed priority encoder, or an acknowledge that clears the wrong bit, would show the wrong index.

It lines up a write-one-to-clear with the very cycle an edge lands. A design that let the clear win would drop that interrupt.

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] reg_addr,
  input  logic       reg_wr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic [7:0] pad_in,
  input  logic [7:0] pad_oe,
  input  logic [7:0] pad_out,
  input  logic       gie,
  input  logic       ack_valid,
  input  logic [2:0] ack_index,
  output logic       irq_valid,
  output logic [2:0] irq_index
);
  localparam int N = 8;

  logic [N-1:0]   sense_lo, sense_hi, mask_q, flag_q;
  logic [N-1:0]   sync1, sync2, prev;
  logic [2*N-1:0] sense, sense_nxt;
  logic [N-1:0]   pin_eff, rise, fall;
  logic [N-1:0]   set_evt, lvl, lvl_nxt, clr, flag_nxt, pend;

  assign pin_eff = (pad_oe & pad_out) | (~pad_oe & pad_in);
  assign rise    = sync2 & ~prev;
  assign fall    = ~sync2 & prev;
  assign sense   = {sense_hi, sense_lo};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
      prev  <= '0;
    end else begin
      sync1 <= pin_eff;
      sync2 <= sync1;
      prev  <= sync2;
    end
  end

  always_comb begin
    sense_nxt = sense;
    if (reg_wr && reg_addr == 2'd0) sense_nxt[7:0]  = reg_wdata;
    if (reg_wr && reg_addr == 2'd1) sense_nxt[15:8] = reg_wdata;
  end

  always_comb begin
    for (int i = 0; i < N; i++) begin
      lvl[i]     = (sense[2*i +: 2] == 2'b00);
      lvl_nxt[i] = (sense_nxt[2*i +: 2] == 2'b00);
      case (sense[2*i +: 2])
        2'b01:   set_evt[i] = rise[i] | fall[i];
        2'b10:   set_evt[i] = fall[i];
        2'b11:   set_evt[i] = rise[i];
        default: set_evt[i] = 1'b0;
      endcase
    end
  end

  assign clr = ((reg_wr && reg_addr == 2'd3) ? reg_wdata : '0)
             | (ack_valid ? (8'd1 << ack_index) : '0);
  assign flag_nxt = ~lvl_nxt & (set_evt | (flag_q & ~clr));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sense_lo <= '0;
      sense_hi <= '0;
      mask_q   <= '0;
      flag_q   <= '0;
    end else begin
      sense_lo <= sense_nxt[7:0];
      sense_hi <= sense_nxt[15:8];
      if (reg_wr && reg_addr == 2'd2) mask_q <= reg_wdata;
      flag_q <= flag_nxt;
    end
  end

  assign pend      = mask_q & ((lvl & ~sync2) | (~lvl & flag_q));
  assign irq_valid = gie & (|pend);

  always_comb begin
    irq_index = '0;
    for (int i = N - 1; i >= 0; i--)
      if (pend[i]) irq_index = 3'(i);
  end

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = sense_lo;
      2'd1:    reg_rdata = sense_hi;
      2'd2:    reg_rdata = mask_q;
      default: reg_rdata = flag_q;
    endcase
  end
endmodule

// File: rtl/ext_irq_ctrl_chk.sv
module ext_irq_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       gie,
  input logic       ack_valid,
  input logic [2:0] ack_index,
  input logic       irq_valid,
  input logic [2:0] irq_index,
  input logic [7:0] flag_q,
  input logic [7:0] set_evt,
  input logic [7:0] lvl,
  input logic [7:0] pend
);
  a_r7_req_needs_gie: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> gie);

  a_r8_lowest_index: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> (pend[irq_index] && ((pend & ((8'd1 << irq_index) - 8'd1)) == 8'd0)));

  a_r6_level_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q & lvl) == 8'd0);

  a_r3_edge_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (set_evt != 8'd0) |=> ((flag_q & $past(set_evt) & ~lvl) == ($past(set_evt) & ~lvl)));

  a_r5_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid && !set_evt[ack_index]) |=> !flag_q[$past(ack_index)]);
endmodule

bind ext_irq_ctrl ext_irq_ctrl_chk chk_i (
  .clk(clk), .rst_n(rst_n), .gie(gie), .ack_valid(ack_valid), .ack_index(ack_index),
  .irq_valid(irq_valid), .irq_index(irq_index), .flag_q(flag_q), .set_evt(set_evt),
  .lvl(lvl), .pend(pend)
);

// File: tb/ext_irq_ctrl_tb_top.sv
module ext_irq_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] reg_addr = '0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic [7:0] pad_in = '0, pad_oe = '0, pad_out = '0;
  logic       gie = 1'b0, ack_valid = 1'b0;
  logic [2:0] ack_index = '0;
  logic       irq_valid;
  logic [2:0] irq_index;
  int checks = 0, failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ext_irq_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out), .gie(gie),
    .ack_valid(ack_valid), .ack_index(ack_index), .irq_valid(irq_valid), .irq_index(irq_index)
  );

  // {mode[1:0], start level, end level, expected flag} on channel 2
  localparam logic [4:0] VEC [7] = '{
    {2'b01, 1'b0, 1'b1, 1'b1}, {2'b01, 1'b1, 1'b0, 1'b1},
    {2'b10, 1'b1, 1'b0, 1'b1}, {2'b10, 1'b0, 1'b1, 1'b0},
    {2'b11, 1'b0, 1'b1, 1'b1}, {2'b11, 1'b1, 1'b0, 1'b0},
    {2'b00, 1'b1, 1'b0, 1'b0}
  };

  task automatic step(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    step(1);
    reg_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    step(2);
    rst_n = 1'b1;
    step(1);
    bus_read(2'd0, rd); check("R1 sense_lo", rd, 8'h00);
    bus_read(2'd2, rd); check("R1 mask", rd, 8'h00);
    bus_read(2'd3, rd); check("R1 flags", rd, 8'h00);
    check("R1 irq_valid", {7'd0, irq_valid}, 8'h00);

    bus_write(2'd2, 8'hA5);
    bus_read(2'd2, rd); check("R2 mask readback", rd, 8'hA5);
    bus_write(2'd1, 8'h6C);
    bus_read(2'd1, rd); check("R2 sense_hi readback", rd, 8'h6C);
    bus_write(2'd2, 8'h00);
    bus_write(2'd1, 8'h00);

    foreach (VEC[v]) begin
      bus_write(2'd0, {2'b00, VEC[v][4:3], 4'b0000});
      pad_in[2] = VEC[v][2];
      step(4);
      bus_write(2'd3, 8'hFF);
      pad_in[2] = VEC[v][1];
      step(4);
      bus_read(2'd3, rd);
      check((VEC[v][4:3] == 2'b00) ? "R6 level flag" : (VEC[v][0] ? "R3 edge flag" : "R11 ignored edge"),
            {7'd0, rd[2]}, {7'd0, VEC[v][0]});
    end

    pad_in = 8'hFF;
    bus_write(2'd0, 8'hFF);
    bus_write(2'd1, 8'hFF);
    step(4);
    bus_write(2'd3, 8'hFF);

    pad_in[3] = 1'b0; step(4);
    bus_write(2'd3, 8'hFF);
    pad_in[3] = 1'b1; step(4);
    bus_read(2'd3, rd); check("R3 unmasked flag", rd, 8'h08);
    check("R7 mask off", {7'd0, irq_valid}, 8'h00);
    bus_write(2'd2, 8'h08); step(1);
    check("R7 gie off", {7'd0, irq_valid}, 8'h00);
    gie = 1'b1; step(1);
    check("R7 request", {4'd0, irq_valid, irq_index}, 8'h0B);

    pad_in[1] = 1'b0; step(4);
    pad_in[1] = 1'b1; step(4);
    bus_write(2'd2, 8'h0A); step(1);
    check("R8 lowest index", {4'd0, irq_valid, irq_index}, 8'h09);

    ack_valid = 1'b1; ack_index = 3'd1; step(1); ack_valid = 1'b0;
    bus_read(2'd3, rd); check("R5 ack clears", rd, 8'h08);
    check("R5 next index", {4'd0, irq_valid, irq_index}, 8'h0B);

    bus_write(2'd3, 8'h00);
    bus_read(2'd3, rd); check("R4 zero keeps", rd, 8'h08);
    bus_write(2'd3, 8'h08);
    bus_read(2'd3, rd); check("R4 one clears", rd, 8'h00);
    check("R4 request drops", {7'd0, irq_valid}, 8'h00);

    bus_write(2'd1, 8'hF3);
    bus_write(2'd2, 8'h20);
    pad_in[5] = 1'b0; step(3);
    check("R6 level request", {4'd0, irq_valid, irq_index}, 8'h0D);
    bus_read(2'd3, rd); check("R6 level flag zero", rd, 8'h00);
    pad_in[5] = 1'b1; step(3);
    check("R6 level release", {7'd0, irq_valid}, 8'h00);
    bus_write(2'd1, 8'hFF);

    bus_write(2'd2, 8'h00);
    pad_oe[6] = 1'b1; pad_out[6] = 1'b0; step(4);
    bus_write(2'd3, 8'hFF);
    pad_out[6] = 1'b1; step(4);
    bus_read(2'd3, rd); check("R9 driven pin", rd, 8'h40);
    bus_write(2'd3, 8'hFF);

    pad_in[0] = 1'b0; step(4);
    bus_write(2'd3, 8'hFF);
    pad_in[0] = 1'b1; step(2);
    bus_write(2'd3, 8'hFF);
    bus_read(2'd3, rd); check("R10 edge beats clear", rd, 8'h01);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule